// File: doc/BRIEF.md
# Bit-Slice 32-bit Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit for a 32-bit integer datapath. It is built as a chain of one-bit slices. Every slice holds a full adder, optional inverters on both operands, and a four-way output selector. A 3-bit control code picks bitwise AND, bitwise OR, addition, subtraction or set-on-less-than. The result comes with a zero flag, the carry out of the top bit and a signed overflow flag.

Subtraction runs on the same adder: the most significant control bit inverts operand B and also feeds the carry into bit 0. Set-on-less-than takes the sign bit of the difference from the top slice and routes it back to the less input of bit 0. Overflow is only a flag, and nothing traps on it. The width is a parameter; the default is 32.

Top module: `salu_top`

## Requirements
- R1: Code 3'b000 gives result = A & B.
- R2: Code 3'b001 gives result = A | B.
- R3: Code 3'b010 gives result = (A + B) mod 2^32, and carry_out equals bit 32 of the unsigned 33-bit sum.
- R4: Code 3'b110 gives result = (A - B) mod 2^32, formed as A + ~B + 1. carry_out is bit 32 of that sum, so it is 1 exactly when A >= B unsigned.
- R5: Code 3'b111 places bit 31 of (A - B) mod 2^32 in result bit 0 and clears bits 31..1. When the subtraction does not overflow, bit 0 equals the signed comparison A < B.
- R6: zero is 1 exactly when all result bits are 0, for every code.
- R7: The adder always adds A to B (code bit 2 = 0) or to ~B with carry-in 1 (code bit 2 = 1). carry_out is the carry out of bit 31. overflow is the carry into bit 31 XOR the carry out of bit 31, which is 1 exactly when both adder operands share a sign that the sum does not.
- R8: The unlisted codes decode by the same fields, where code bit 2 inverts B and code bits 1:0 select 00 AND, 01 OR, 10 sum, 11 less. So 3'b100 gives A & ~B, 3'b101 gives A | ~B, and 3'b011 places bit 31 of (A + B) in result bit 0 with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| alu_ctl | input | 3 | Operation code |
| alu_res | output | 32 | Result |
| zero | output | 1 | Result is all zeros |
| carry_out | output | 1 | Carry out of the top bit |
| overflow | output | 1 | Signed overflow of the adder |

## Verification
All eight codes are driven with directed pairs and with random operands. The directed pairs are all-zero, all-one, maxint and minint combinations, equal operands, and operands whose difference is ±1:
- Equal operands and zero pairs separate a correct zero flag from one stuck at 0.
- The maxint/minint pairs force signed overflow in both directions. They show whether overflow comes from the top carries and not from the carry out alone.
- Pairs that differ only in the low bits check that the set-on-less-than bit lands in bit 0.
- Random pairs exercise the full carry chain.
- The unlisted codes confirm field-based decoding of the B-invert and select fields.

// File: rtl/salu_pkg.sv
// Shared types for the bit-slice ALU.
// Assumes the slice selector is 2 bits wide and the control code 3 bits wide.
package salu_pkg;

    // Per-slice output selection.
    typedef enum logic [1:0] {
        SEL_AND  = 2'b00,
        SEL_OR   = 2'b01,
        SEL_SUM  = 2'b10,
        SEL_LESS = 2'b11
    } slice_sel_e;

    // Control codes seen at the top-level port.
    localparam logic [2:0] CTL_AND = 3'b000;
    localparam logic [2:0] CTL_OR  = 3'b001;
    localparam logic [2:0] CTL_ADD = 3'b010;
    localparam logic [2:0] CTL_SUB = 3'b110;
    localparam logic [2:0] CTL_SLT = 3'b111;

    // Four-way pick of a slice output from its candidate values.
    function automatic logic slice_pick(input slice_sel_e sel,
                                        input logic and_v,
                                        input logic or_v,
                                        input logic sum_v,
                                        input logic less_v);
        logic r;
        case (sel)
            SEL_AND: r = and_v;
            SEL_OR:  r = or_v;
            SEL_SUM: r = sum_v;
            default: r = less_v;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/salu_fa.sv
// One-bit full adder.
// Purely combinational; carry out is the majority of the three inputs.
module salu_fa (
    input  logic x_i,
    input  logic y_i,
    input  logic ci_i,
    output logic s_o,
    output logic co_o
);
    // Sum and majority carry.
    always_comb begin
        s_o  = x_i ^ y_i ^ ci_i;
        co_o = (x_i & y_i) | (x_i & ci_i) | (y_i & ci_i);
    end
endmodule

// File: rtl/salu_bit.sv
// One-bit ALU slice for all but the most significant position.
// Assumes the inverted operands feed the logic and adder stages alike.
module salu_bit
    import salu_pkg::*;
(
    input  logic       a_i,
    input  logic       b_i,
    input  logic       a_inv,
    input  logic       b_inv,
    input  logic       less_i,
    input  slice_sel_e sel_i,
    input  logic       cin_i,
    output logic       res_o,
    output logic       cout_o
);
    logic a_eff;
    logic b_eff;
    logic sum;

    // Optional operand inversion.
    always_comb begin
        a_eff = a_i ^ a_inv;
        b_eff = b_i ^ b_inv;
    end

    salu_fa u_fa (
        .x_i  (a_eff),
        .y_i  (b_eff),
        .ci_i (cin_i),
        .s_o  (sum),
        .co_o (cout_o)
    );

    // Output selection.
    always_comb res_o = slice_pick(sel_i, a_eff & b_eff, a_eff | b_eff, sum, less_i);
endmodule

// File: rtl/salu_bit_msb.sv
// Most significant ALU slice.
// Behaves like the ordinary slice and also exposes its raw sum (the
// set-on-less-than source) and the XOR of its carry in and carry out
// (signed overflow).
module salu_bit_msb
    import salu_pkg::*;
(
    input  logic       a_i,
    input  logic       b_i,
    input  logic       a_inv,
    input  logic       b_inv,
    input  logic       less_i,
    input  slice_sel_e sel_i,
    input  logic       cin_i,
    output logic       res_o,
    output logic       cout_o,
    output logic       set_o,
    output logic       ovf_o
);
    logic a_eff;
    logic b_eff;
    logic sum;

    // Optional operand inversion.
    always_comb begin
        a_eff = a_i ^ a_inv;
        b_eff = b_i ^ b_inv;
    end

    salu_fa u_fa (
        .x_i  (a_eff),
        .y_i  (b_eff),
        .ci_i (cin_i),
        .s_o  (sum),
        .co_o (cout_o)
    );

    // Output selection, the set bit, and the overflow from the top carries.
    always_comb begin
        res_o = slice_pick(sel_i, a_eff & b_eff, a_eff | b_eff, sum, less_i);
        set_o = sum;
        ovf_o = cin_i ^ cout_o;
    end
endmodule

// File: rtl/salu_decode.sv
// Control-code decoder.
// Bit 2 inverts B (and is the bit-0 carry-in); bits 1:0 pick the slice output.
// A is never inverted by the defined codes.
module salu_decode
    import salu_pkg::*;
(
    input  logic [2:0] ctl_i,
    output logic       a_inv_o,
    output logic       b_inv_o,
    output slice_sel_e sel_o
);
    // Split the code into its fields.
    always_comb begin
        a_inv_o = 1'b0;
        b_inv_o = ctl_i[2];
        sel_o   = slice_sel_e'(ctl_i[1:0]);
    end
endmodule

// File: rtl/salu_top.sv
// Bit-slice ALU top.
// Chains WIDTH one-bit slices through a ripple carry. The top slice's sum
// returns to the less input of bit 0 for set-on-less-than.
// Assumes WIDTH >= 2. Purely combinational.
module salu_top
    import salu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [2:0]       alu_ctl,
    output logic [WIDTH-1:0] alu_res,
    output logic             zero,
    output logic             carry_out,
    output logic             overflow
);
    localparam int MSB = WIDTH - 1;

    logic       a_inv;
    logic       b_inv;
    slice_sel_e sel;
    logic [WIDTH:0] carry;
    logic       set_msb;
    logic       ovf_msb;

    salu_decode u_dec (
        .ctl_i   (alu_ctl),
        .a_inv_o (a_inv),
        .b_inv_o (b_inv),
        .sel_o   (sel)
    );

    // Subtraction needs the +1 of two's complement at bit 0.
    always_comb carry[0] = b_inv;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        if (i == MSB) begin : g_top
            salu_bit_msb u_bit (
                .a_i    (opnd_a[i]),
                .b_i    (opnd_b[i]),
                .a_inv  (a_inv),
                .b_inv  (b_inv),
                .less_i (1'b0),
                .sel_i  (sel),
                .cin_i  (carry[i]),
                .res_o  (alu_res[i]),
                .cout_o (carry[i+1]),
                .set_o  (set_msb),
                .ovf_o  (ovf_msb)
            );
        end else begin : g_low
            salu_bit u_bit (
                .a_i    (opnd_a[i]),
                .b_i    (opnd_b[i]),
                .a_inv  (a_inv),
                .b_inv  (b_inv),
                .less_i ((i == 0) ? set_msb : 1'b0),
                .sel_i  (sel),
                .cin_i  (carry[i]),
                .res_o  (alu_res[i]),
                .cout_o (carry[i+1])
            );
        end
    end

    // Status flags.
    always_comb begin
        zero      = ~|alu_res;
        carry_out = carry[WIDTH];
        overflow  = ovf_msb;
    end
endmodule

// File: rtl/salu_checker.sv
// Port-level checks for salu_top; immediate assertions because the block
// has no clock. Bound to every salu_top instance below.
module salu_checker #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic [2:0]       alu_ctl,
    input logic [WIDTH-1:0] alu_res,
    input logic             zero,
    input logic             carry_out,
    input logic             overflow
);
    logic [WIDTH:0] add_full;
    logic [WIDTH:0] sub_full;

    // Reference sums by plain arithmetic.
    always_comb begin
        add_full = {1'b0, opnd_a} + {1'b0, opnd_b};
        sub_full = {1'b0, opnd_a} + {1'b0, ~opnd_b} + {{WIDTH{1'b0}}, 1'b1};
    end

    // Port relations per code.
    always_comb begin
        if (alu_ctl == 3'b000)
            assert_and_R1: assert (alu_res == (opnd_a & opnd_b)) else $error("AND mismatch");
        if (alu_ctl == 3'b001)
            assert_or_R2: assert (alu_res == (opnd_a | opnd_b)) else $error("OR mismatch");
        if (alu_ctl == 3'b010)
            assert_add_R3: assert ({carry_out, alu_res} == add_full) else $error("ADD mismatch");
        if (alu_ctl == 3'b110)
            assert_sub_R4: assert ({carry_out, alu_res} == sub_full) else $error("SUB mismatch");
        if (alu_ctl == 3'b111)
            assert_slt_R5: assert (alu_res[WIDTH-1:1] == '0 && alu_res[0] == sub_full[WIDTH-1])
                else $error("SLT mismatch");
        assert_zero_R6: assert (zero == (alu_res == '0)) else $error("zero flag mismatch");
        if (alu_ctl == 3'b010)
            assert_ovf_add_R7: assert (overflow ==
                ((opnd_a[WIDTH-1] == opnd_b[WIDTH-1]) && (alu_res[WIDTH-1] != opnd_a[WIDTH-1])))
                else $error("add overflow mismatch");
        if (alu_ctl == 3'b100)
            assert_andn_R8: assert (alu_res == (opnd_a & ~opnd_b)) else $error("AND-NOT mismatch");
    end
endmodule

bind salu_top salu_checker #(.WIDTH(WIDTH)) u_salu_chk (
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .alu_ctl   (alu_ctl),
    .alu_res   (alu_res),
    .zero      (zero),
    .carry_out (carry_out),
    .overflow  (overflow)
);

// File: tb/salu_top_tb.sv
`timescale 1ns/1ps
// Bench for salu_top: drives one operation per cycle at the rising edge and
// compares all outputs with a behavioural model at the falling edge.
module salu_top_tb;
    logic        clk = 1'b0;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic [2:0]  ctl = '0;
    logic [31:0] res;
    logic        zero, cout, ovf;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 0;

    always #4 clk = ~clk;   // 125 MHz

    salu_top #(.WIDTH(32)) u_dut (
        .opnd_a(a), .opnd_b(b), .alu_ctl(ctl),
        .alu_res(res), .zero(zero), .carry_out(cout), .overflow(ovf)
    );

    function automatic string res_tag(input logic [2:0] c);
        case (c)
            3'b000: return "R1";
            3'b001: return "R2";
            3'b010: return "R3";
            3'b110: return "R4";
            3'b111: return "R5";
            default: return "R8";
        endcase
    endfunction

    task automatic cmp(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h (ctl=%b a=%h b=%h)",
                     tag, what, act, exp, ctl, a, b);
        end
    endtask

    // Apply one operation and check it half a cycle later.
    task automatic run(input logic [2:0] c, input logic [31:0] x, input logic [31:0] y);
        longint unsigned s;
        logic [31:0] bb, e_res;
        logic        e_c, e_v, sgn;
        @(posedge clk);
        ctl = c; a = x; b = y;
        bb  = c[2] ? ~y : y;
        s   = longint'(x) + longint'(bb) + (c[2] ? 64'd1 : 64'd0);
        sgn = s[31];
        e_c = s[32];
        e_v = (x[31] == bb[31]) && (sgn != x[31]);
        case (c)
            3'b000: e_res = x & y;
            3'b001: e_res = x | y;
            3'b010: e_res = x + y;
            3'b110: e_res = x - y;
            3'b111: e_res = {31'd0, sgn};
            3'b100: e_res = x & ~y;
            3'b101: e_res = x | ~y;
            default: e_res = {31'd0, sgn};
        endcase
        @(negedge clk);
        cmp(res_tag(c), "result", res, e_res);
        cmp("R6", "zero", {31'd0, zero}, {31'd0, (e_res == 32'd0)});
        cmp(c == 3'b010 ? "R3" : (c == 3'b110 ? "R4" : "R7"), "carry_out",
            {31'd0, cout}, {31'd0, e_c});
        cmp("R7", "overflow", {31'd0, ovf}, {31'd0, e_v});
        if (c == 3'b111 && !e_v)   // R5 signed meaning when no overflow
            cmp("R5", "signed-less", {31'd0, res[0]},
                {31'd0, ($signed(x) < $signed(y))});
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        logic [31:0] pa [10];
        logic [31:0] pb [10];
        logic [2:0]  codes [8];
        codes = '{3'b000, 3'b001, 3'b010, 3'b110, 3'b111, 3'b011, 3'b100, 3'b101};
        pa = '{32'h0, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000, 32'h1234_5678,
               32'h7FFF_FFFF, 32'h8000_0000, 32'h0000_0005, 32'hFFFF_FFFE, 32'h0000_0001};
        pb = '{32'h0, 32'hFFFF_FFFF, 32'h0000_0001, 32'hFFFF_FFFF, 32'h1234_5678,
               32'h8000_0000, 32'h0000_0001, 32'h0000_0006, 32'hFFFF_FFFF, 32'hFFFF_FFFF};
        // Directed corners for every code (R1..R8).
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 10; j++) begin
                run(codes[i], pa[j], pb[j]);
                run(codes[i], pb[j], pa[j]);
            end
        // Random operands, all codes.
        for (int k = 0; k < 3000; k++)
            run(codes[k % 8], $urandom, $urandom);
        // Small magnitudes around zero stress the sign of the difference (R5).
        for (int k = 0; k < 400; k++)
            run(3'b111, $urandom_range(0, 8) - 4, $urandom_range(0, 8) - 4);
        done = 1;
        summary();
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
        end
    end
endmodule